// File: doc/BRIEF.md
# Passive LCD Strobe Generator

This block produces the control strobes and the 4-bit data bus for a single-colour passive LCD panel. A memory-clock divider makes a pixel tick (Ts). Each tick advances a raster position made of a horizontal position `h`, counted in Ts within a line, and a line index `v` within a frame. Every output is a registered function of the position it has just entered. The outputs are the line pulse, the frame pulse, the shift clock, the AC-drive toggle and the pixel nibble. They change only on the clock edge where the position advances, and they line up with that position.

A line lasts `D + N + 33` Ts, where `D = (cfg_hdisp+1)*8` and `N = (cfg_hblank+1)*8`. The line pulse covers `h` = 0..8, so its falling edge is at `h` = 9. The display window is `h` in `[10, 10+D)`, and only lines `v <= cfg_vdisp` use it. In the window the shift clock runs with a period of 4 Ts: it is high for the first two ticks of each slot and low for the last two. One nibble is launched per slot. It is held for the whole slot, so it is stable around the falling edge of the shift clock in the middle of the slot. The nibble comes from an upstream source through `pix_req`/`pix_valid`. A frame has `cfg_vdisp + cfg_vblank + 2` lines.

Top module: `lcd_strobe_gen`

## Requirements
- R1: A pixel tick occurs once every `cfg_div+1` memory clocks, and the raster position advances only on a tick. Consecutive nibble requests within one line are therefore `4*(cfg_div+1)` clocks apart.
- R2: Rising edges of `lcd_line` are `(D+N+33)*(cfg_div+1)` memory clocks apart, with `D=(cfg_hdisp+1)*8` and `N=(cfg_hblank+1)*8`.
- R3: `lcd_line` is high (active-high) exactly while `h` is 0 to 8, which is 9 Ts. Its falling edge is therefore at `h` = 9.
- R4: `lcd_frame` is high from `h` = 18 of the last line of a frame through `h` = 17 of line 0. This places it one line period minus 9 Ts before the falling edge of the line pulse on line 0, and holds it for 9 Ts after that edge.
- R5: `lcd_mod` toggles once per frame, at the position `D-1` Ts before the falling edge of the line pulse on line 0. That position is `h = N+43` on the last line, or `h` = 2 on line 0 when `cfg_hdisp` is 0.
- R6: On display lines with `h` in `[10,10+D)`, `lcd_shift` is high when `(h-10) mod 4` is 0 or 1 and low otherwise. It is low everywhere else.
- R7: `pix_req` is high for exactly the clock in which a tick moves the position onto a slot start on a display line, where `(h-10) mod 4 = 0`. If `pix_valid` is high in that clock, `pix_data` appears on `lcd_data` for the whole 4-Ts slot.
- R8: A slot whose request finds `pix_valid` low shows 0 on `lcd_data`. `lcd_data` is also 0 outside the display window.
- R9: While `rst_n` is low the position is `(h,v) = (0,0)`, the divider phase is 0, `lcd_line` and `lcd_frame` are 1, and `lcd_shift`, `lcd_mod`, `lcd_data` and `pix_req` are 0.
- R10: Lines with `v > cfg_vdisp` are non-display lines: they carry no shift pulses and no requests. After the last line, `v = cfg_vdisp+cfg_vblank+1`, the position wraps to `(0,0)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Pixel tick every cfg_div+1 clocks |
| cfg_hdisp | input | HD_W | Display span, (value+1)*8 Ts |
| cfg_hblank | input | HN_W | Non-display span, (value+1)*8 Ts |
| cfg_vdisp | input | VL_W | Display lines minus one |
| cfg_vblank | input | VL_W | Non-display lines minus one |
| pix_req | output | 1 | Nibble request, one clock per slot |
| pix_valid | input | 1 | Upstream nibble valid with the request |
| pix_data | input | DATA_W | Upstream nibble |
| lcd_frame | output | 1 | Frame pulse |
| lcd_line | output | 1 | Line pulse |
| lcd_shift | output | 1 | Shift clock |
| lcd_mod | output | 1 | AC-drive toggle |
| lcd_data | output | DATA_W | Pixel nibble to the panel |

## Verification
Every strobe and the data bus are due on the same clock edge that moves the raster to the position they describe. They are therefore read just after the falling edge that follows that rising edge, and compared with a position model that the bench advances once per predicted tick. `pix_req` is combinational in the tick cycle itself. The bench compares it before advancing its model, from the divider phase it predicts and the next position. Line periods and request spacing are measured in clocks between observed edges. The sweep covers every divider setting, the narrow and wider spans, and both orders of display and non-display line counts.

// File: rtl/lcd_strobe_pkg.sv
package lcd_strobe_pkg;
    // Positions within a line, in pixel ticks
    localparam int LP_TS         = 9;   // line pulse covers h < LP_TS
    localparam int FP_EDGE_TS    = 18;  // frame pulse boundary
    localparam int DISP_START_TS = 10;  // first display tick
    localparam int LINE_OVH_TS   = 33;  // fixed overhead per line
    localparam int MOD_ANCHOR_TS = 43;  // toggle offset after the blank span
    localparam int MOD_WRAP_TS   = 2;   // toggle position when it wraps to line 0
    localparam int SLOT_TS       = 4;   // ticks per nibble slot

    typedef struct packed {
        logic lp;
        logic fp;
        logic sh;
        logic md;
    } strobe_t;
endpackage

// File: rtl/lcd_pix_tick.sv
module lcd_pix_tick #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    typedef struct packed {
        logic [SEL_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick   = (st_q.cnt == div_sel);
        st_d.cnt = tick ? '0 : st_q.cnt + SEL_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel != '0) |=> !tick);
endmodule

// File: rtl/lcd_raster_cnt.sv
module lcd_raster_cnt
    import lcd_strobe_pkg::*;
#(
    parameter int HD_W = 7,
    parameter int HN_W = 5,
    parameter int VL_W = 10,
    parameter int H_W  = 11,
    parameter int V_W  = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [HD_W-1:0] hdisp,
    input  logic [HN_W-1:0] hblank,
    input  logic [VL_W-1:0] vdisp,
    input  logic [VL_W-1:0] vblank,
    output logic [H_W-1:0]  h_q,
    output logic [V_W-1:0]  v_q,
    output logic [H_W-1:0]  h_nx,
    output logic [V_W-1:0]  v_nx,
    output logic [H_W-1:0]  d_span,
    output logic [H_W-1:0]  n_span,
    output logic [V_W-1:0]  v_last
);
    typedef struct packed {
        logic [H_W-1:0] h;
        logic [V_W-1:0] v;
    } pos_t;

    pos_t           pos_d, pos_q;
    logic [H_W-1:0] line_len;

    always_comb begin
        d_span   = (H_W'(hdisp) + H_W'(1)) << 3;
        n_span   = (H_W'(hblank) + H_W'(1)) << 3;
        line_len = d_span + n_span + H_W'(LINE_OVH_TS);
        v_last   = V_W'(vdisp) + V_W'(vblank) + V_W'(1);

        if (pos_q.h == line_len - H_W'(1)) begin
            h_nx = '0;
            v_nx = (pos_q.v == v_last) ? '0 : pos_q.v + V_W'(1);
        end else begin
            h_nx = pos_q.h + H_W'(1);
            v_nx = pos_q.v;
        end

        pos_d = pos_q;
        if (tick) begin
            pos_d.h = h_nx;
            pos_d.v = v_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign h_q = pos_q.h;
    assign v_q = pos_q.v;

    // R2
    h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_q < line_len);

    // R10
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && h_q == line_len - H_W'(1) && v_q == v_last) |=> (h_q == '0 && v_q == '0));
endmodule

// File: rtl/lcd_strobe_gen.sv
module lcd_strobe_gen
    import lcd_strobe_pkg::*;
#(
    parameter int DIV_W  = 2,
    parameter int HD_W   = 7,
    parameter int HN_W   = 5,
    parameter int VL_W   = 10,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [HD_W-1:0]   cfg_hdisp,
    input  logic [HN_W-1:0]   cfg_hblank,
    input  logic [VL_W-1:0]   cfg_vdisp,
    input  logic [VL_W-1:0]   cfg_vblank,
    output logic              pix_req,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              lcd_frame,
    output logic              lcd_line,
    output logic              lcd_shift,
    output logic              lcd_mod,
    output logic [DATA_W-1:0] lcd_data
);
    localparam int H_W = $clog2((2**HD_W) * 8 + (2**HN_W) * 8 + LINE_OVH_TS + 1);
    localparam int V_W = VL_W + 1;

    typedef struct packed {
        strobe_t           st;
        logic [DATA_W-1:0] data;
    } out_t;

    logic           tick;
    logic [H_W-1:0] h_q, h_nx, d_span, n_span, k_nx, ph_nx;
    logic [V_W-1:0] v_q, v_nx, v_last;
    logic           disp_line_nx, in_disp_nx, slot_nx, fp_nx, tog_nx;
    out_t           out_d, out_q;

    lcd_pix_tick #(.SEL_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div_sel(cfg_div), .tick(tick)
    );

    lcd_raster_cnt #(
        .HD_W(HD_W), .HN_W(HN_W), .VL_W(VL_W), .H_W(H_W), .V_W(V_W)
    ) u_raster (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .hdisp(cfg_hdisp), .hblank(cfg_hblank), .vdisp(cfg_vdisp), .vblank(cfg_vblank),
        .h_q(h_q), .v_q(v_q), .h_nx(h_nx), .v_nx(v_nx),
        .d_span(d_span), .n_span(n_span), .v_last(v_last)
    );

    always_comb begin
        k_nx         = h_nx - H_W'(DISP_START_TS);
        ph_nx        = k_nx % H_W'(SLOT_TS);
        disp_line_nx = (v_nx <= V_W'(cfg_vdisp));
        in_disp_nx   = disp_line_nx && (h_nx >= H_W'(DISP_START_TS))
                       && (h_nx < d_span + H_W'(DISP_START_TS));
        slot_nx      = in_disp_nx && (ph_nx == '0);
        fp_nx        = ((v_nx == v_last) && (h_nx >= H_W'(FP_EDGE_TS)))
                       || ((v_nx == '0) && (h_nx < H_W'(FP_EDGE_TS)));
        if (cfg_hdisp == '0)
            tog_nx = (v_nx == '0) && (h_nx == H_W'(MOD_WRAP_TS));
        else
            tog_nx = (v_nx == v_last) && (h_nx == n_span + H_W'(MOD_ANCHOR_TS));

        pix_req = tick && slot_nx;

        out_d = out_q;
        if (tick) begin
            out_d.st.lp = (h_nx < H_W'(LP_TS));
            out_d.st.fp = fp_nx;
            out_d.st.sh = in_disp_nx && (ph_nx < H_W'(SLOT_TS / 2));
            out_d.st.md = out_q.st.md ^ tog_nx;
            if (slot_nx)
                out_d.data = pix_valid ? pix_data : '0;
            else if (!in_disp_nx)
                out_d.data = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q       <= '0;
            out_q.st.lp <= 1'b1;
            out_q.st.fp <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign lcd_line  = out_q.st.lp;
    assign lcd_frame = out_q.st.fp;
    assign lcd_shift = out_q.st.sh;
    assign lcd_mod   = out_q.st.md;
    assign lcd_data  = out_q.data;

    // R3
    line_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_line) |-> (h_q == '0));

    // R4
    frame_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_frame) |-> (h_q == H_W'(FP_EDGE_TS) && v_q == '0));

    // R5
    mod_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lcd_mod) |-> $past(tick));

    // R7
    req_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> tick);

    // R8
    pulse_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_line |-> (lcd_data == '0));

    // R10
    blank_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q > V_W'(cfg_vdisp)) |-> !lcd_shift);
endmodule

// File: tb/lcd_strobe_gen_tb.sv
module lcd_strobe_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_div = '0;
    logic [6:0] cfg_hdisp = '0;
    logic [4:0] cfg_hblank = '0;
    logic [9:0] cfg_vdisp = '0;
    logic [9:0] cfg_vblank = '0;
    logic       pix_req;
    logic       pix_valid = 1'b0;
    logic [3:0] pix_data = '0;
    logic       lcd_frame, lcd_line, lcd_shift, lcd_mod;
    logic [3:0] lcd_data;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    int  D, N, P, VT, DL, S;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_strobe_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_hdisp(cfg_hdisp),
        .cfg_hblank(cfg_hblank), .cfg_vdisp(cfg_vdisp), .cfg_vblank(cfg_vblank),
        .pix_req(pix_req), .pix_valid(pix_valid), .pix_data(pix_data),
        .lcd_frame(lcd_frame), .lcd_line(lcd_line), .lcd_shift(lcd_shift),
        .lcd_mod(lcd_mod), .lcd_data(lcd_data)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (div=%0d hd=%0d hn=%0d vd=%0d vn=%0d)",
                     tag, act, exp, cfg_div, cfg_hdisp, cfg_hblank, cfg_vdisp, cfg_vblank);
        end
    endtask

    function automatic bit in_win(int h, int v);
        return (v < DL) && (h >= 10) && (h < 10 + D);
    endfunction

    function automatic bit frame_exp(int h, int v);
        return ((v == VT - 1) && (h >= 18)) || ((v == 0) && (h < 18));
    endfunction

    function automatic bit mod_edge(int h, int v);
        int tp;
        tp = P + 10 - D;  // D-1 ticks before the fall at h=9 of line 0
        if (tp >= P) return (v == 0) && (h == tp - P);
        return (v == VT - 1) && (h == tp);
    endfunction

    task automatic run_cfg(int s, int hd, int hn, int vd, int vn);
        int mh, mv, mcnt, mmod, mdata, nh, nv, c, last_rise, lreq_c, lreq_h, lreq_v;
        bit tick, ereq, prev_lp, vld;
        string dtag;
        S = s; D = (hd + 1) * 8; N = (hn + 1) * 8; P = D + N + 33; DL = vd + 1; VT = vd + vn + 2;
        rst_n = 1'b0;
        cfg_div = 2'(s); cfg_hdisp = 7'(hd); cfg_hblank = 5'(hn);
        cfg_vdisp = 10'(vd); cfg_vblank = 10'(vn);
        pix_valid = 1'b0; pix_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk("R9 line", int'(lcd_line), 1);
        chk("R9 frame", int'(lcd_frame), 1);
        chk("R9 shift", int'(lcd_shift), 0);
        chk("R9 mod", int'(lcd_mod), 0);
        chk("R9 data", int'(lcd_data), 0);
        chk("R9 req", int'(pix_req), 0);
        rst_n = 1'b1;
        mh = 0; mv = 0; mcnt = 0; mmod = 0; mdata = 0; dtag = "R8";
        last_rise = -1; lreq_c = -1; lreq_h = -1; lreq_v = -1; prev_lp = 1'b1;
        for (c = 0; c < 2 * P * VT * (s + 1) + 8; c++) begin
            vld = ((c % 5) != 3);
            pix_valid = vld;
            pix_data = 4'((c * 7 + 3) & 15);
            #1;
            chk("R3 line", int'(lcd_line), int'(mh < 9));
            chk("R4 frame", int'(lcd_frame), int'(frame_exp(mh, mv)));
            chk((mv < DL) ? "R6 shift" : "R10 shift", int'(lcd_shift),
                int'(in_win(mh, mv) && (((mh - 10) % 4) < 2)));
            chk("R5 mod", int'(lcd_mod), mmod);
            chk(dtag, int'(lcd_data), mdata);
            if (lcd_line && !prev_lp) begin
                if (last_rise >= 0) chk("R2 period", c - last_rise, P * (s + 1));
                last_rise = c;
            end
            prev_lp = lcd_line;
            tick = (mcnt == s);
            if (mh == P - 1) begin
                nh = 0;
                nv = (mv == VT - 1) ? 0 : mv + 1;
            end else begin
                nh = mh + 1;
                nv = mv;
            end
            ereq = tick && in_win(nh, nv) && (((nh - 10) % 4) == 0);
            chk((nv < DL) ? "R7 req" : "R10 req", int'(pix_req), int'(ereq));
            if (ereq) begin
                if (lreq_v == nv && lreq_h == nh - 4) chk("R1 req spacing", c - lreq_c, 4 * (s + 1));
                lreq_c = c; lreq_h = nh; lreq_v = nv;
            end
            mcnt = tick ? 0 : mcnt + 1;
            if (tick) begin
                mh = nh; mv = nv;
                if (ereq) begin
                    mdata = vld ? int'(pix_data) : 0;
                    dtag = vld ? "R7 data" : "R8 data";
                end else if (!in_win(mh, mv)) begin
                    mdata = 0;
                    dtag = "R8 data";
                end
                if (mod_edge(mh, mv)) mmod ^= 1;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        for (int s = 0; s < 4; s++)
            for (int hd = 0; hd <= 2; hd += 2)
                for (int hn = 0; hn < 2; hn++) begin
                    run_cfg(s, hd, hn, 0, 1);
                    run_cfg(s, hd, hn, 1, 0);
                end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule